// File: doc/BRIEF.md
# Predicated SIMD Halving Subtractor

This block is a vector datapath stage. It treats two equal-length operand vectors as packed unsigned lanes and produces one result vector. In each active lane it subtracts the second operand's lane from the first operand's lane and halves the difference. The subtraction uses one extra bit of precision, so the borrow of a negative difference becomes the top bit of the result. Lanes that the predicate does not select pass the first operand's lane through unchanged, so the result can be written back over the first operand.

A 2-bit size code chooses the lane width for each operation. The predicate has one bit per byte of the vector. A lane is governed by the bit of its lowest byte, and the other bits of that lane are ignored.

The vector length is a parameter and must be a multiple of 64. An operation is offered with `in_valid`, and its result appears in a register one clock later together with `out_valid`. The latency does not depend on operand or predicate values.

Top module: `phsub_core`

## Requirements
- R1: `size_code` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies result bits [i*W +: W].
- R2: An active lane yields bits W..1 of the (W+1)-bit two's-complement difference first minus second. When first < second, the lane's top bit is therefore 1.
- R3: An inactive lane yields the first operand's lane value unchanged.
- R4: Lane i is active when `pmask[i*W/8]` is 1. The other predicate bits covering that lane have no effect.
- R5: There are VLEN/W lanes per operation, and no borrow or carry passes between lanes.
- R6: `out_valid` and `result` update exactly one clock after an accepted `in_valid`, whatever the data values.
- R7: While `in_valid` is low, `result` holds its value and `out_valid` is 0 on the following cycle.
- R8: A synchronous active-low reset clears `out_valid` and `result` to 0.
- R9: With an all-zero predicate, the result equals the first operand.
- R10: With equal operands and all lanes active, the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered this cycle |
| size_code | input | 2 | Lane width select: 0=8, 1=16, 2=32, 3=64 bits |
| opa | input | VLEN | First operand, also the pass-through value |
| opb | input | VLEN | Second operand (subtrahend) |
| pmask | input | VLEN/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result register updated last cycle |
| result | output | VLEN | Registered lane results |

## Verification
The properties assume that `in_valid`, `opa`, `opb` and `pmask` are stable across each sampling edge and are never X while `rst_n` is high. The bench meets this by driving every input on the falling edge only. Properties that refer to the previous operands through `$past` assume that a captured operation is not overlapped by a reset. The bench asserts its mid-run reset only while no operation is being observed. Random operands and masks are drawn from a seeded generator for every size code. They are mixed with directed cases: equal operands, a zero first operand against an all-ones second operand (and the reverse), an empty predicate, and a predicate that leaves each lane's governing bit clear.

// File: rtl/phsub_pkg.sv
// phsub_pkg: shared types and helpers for the halving subtractor.
// Assumes lane widths are powers of two from 8 to 64 bits.
package phsub_pkg;

    localparam int NUM_SIZES = 4;
    localparam int MIN_LANE  = 8;

    typedef enum logic [1:0] {
        LSZ_8  = 2'd0,
        LSZ_16 = 2'd1,
        LSZ_32 = 2'd2,
        LSZ_64 = 2'd3
    } lane_size_e;

    // Lane width in bits for a size code.
    function automatic int lane_bits(input int code);
        return MIN_LANE << code;
    endfunction

endpackage

// File: rtl/phsub_lane.sv
// phsub_lane: one lane of halving subtraction with predicate pass-through.
// Computes bits W..1 of (a - b) taken at W+1 bits, without forming bit 0:
// floor((a-b)/2) = (a>>1) - (b>>1) - (borrow out of bit 0), modulo 2^W.
// Assumes W >= 2.
module phsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         active,
    output logic [W-1:0] y
);

    logic [W-1:0] a_half;
    logic [W-1:0] b_half;
    logic         low_borrow;
    logic [W-1:0] halved;

    // Halving difference built from the upper bits and the bit-0 borrow.
    always_comb begin
        a_half     = {1'b0, a[W-1:1]};
        b_half     = {1'b0, b[W-1:1]};
        low_borrow = ~a[0] & b[0];
        halved     = a_half - b_half - W'(low_borrow);
    end

    // Predicate select: inactive lanes keep the first operand.
    always_comb begin
        y = active ? halved : a;
    end

endmodule

// File: rtl/phsub_width_slice.sv
// phsub_width_slice: all lanes of one fixed lane width across the vector.
// Assumes VLEN is a multiple of LW and that the per-lane active bits are
// already gathered from the byte predicate by the parent.
module phsub_width_slice #(
    parameter int VLEN = 256,
    parameter int LW   = 8
) (
    input  logic [VLEN-1:0]     opa,
    input  logic [VLEN-1:0]     opb,
    input  logic [VLEN/LW-1:0]  lane_act,
    output logic [VLEN-1:0]     res
);

    localparam int NLANES = VLEN / LW;

    // One independent lane per slot; no carry path between slots.
    generate
        for (genvar i = 0; i < NLANES; i++) begin : g_lane
            phsub_lane #(.W(LW)) u_lane (
                .a      (opa[i*LW +: LW]),
                .b      (opb[i*LW +: LW]),
                .active (lane_act[i]),
                .y      (res[i*LW +: LW])
            );
        end
    endgenerate

endmodule

// File: rtl/phsub_core.sv
// phsub_core: predicated packed halving subtractor, one-cycle registered.
// All four lane widths are computed in parallel and the size code picks
// one, so latency never depends on data. Assumes VLEN is a multiple of 64.
module phsub_core
    import phsub_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        size_code,
    input  logic [VLEN-1:0]   opa,
    input  logic [VLEN-1:0]   opb,
    input  logic [VLEN/8-1:0] pmask,
    output logic              out_valid,
    output logic [VLEN-1:0]   result
);

    localparam int PW = VLEN / MIN_LANE;

    logic [VLEN-1:0] slice_res [NUM_SIZES];
    logic [VLEN-1:0] next_res;
    lane_size_e      sel;

    // One slice per lane width, each with its gathered lane predicate.
    generate
        for (genvar c = 0; c < NUM_SIZES; c++) begin : g_width
            localparam int LW  = MIN_LANE << c;
            localparam int NL  = VLEN / LW;
            localparam int STP = LW / MIN_LANE;
            logic [NL-1:0] act;
            for (genvar i = 0; i < NL; i++) begin : g_act
                assign act[i] = pmask[i*STP];
            end
            phsub_width_slice #(.VLEN(VLEN), .LW(LW)) u_slice (
                .opa      (opa),
                .opb      (opb),
                .lane_act (act),
                .res      (slice_res[c])
            );
        end
    endgenerate

    // Lane width select from the size code.
    always_comb begin
        sel = lane_size_e'(size_code);
        unique case (sel)
            LSZ_8:   next_res = slice_res[0];
            LSZ_16:  next_res = slice_res[1];
            LSZ_32:  next_res = slice_res[2];
            default: next_res = slice_res[3];
        endcase
    end

    // Valid pipeline flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register: loads on an accepted operation, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= next_res;
    end

    // Width check kept visible to reviewers (PW = predicate width).
    localparam bit VLEN_OK = (VLEN % 64 == 0) && (PW * MIN_LANE == VLEN);
    generate
        if (!VLEN_OK) begin : g_bad_vlen
            initial $error("phsub_core: VLEN must be a multiple of 64");
        end
    endgenerate

endmodule

// File: rtl/phsub_checker.sv
// phsub_checker: protocol and functional properties for phsub_core.
// Assumes inputs are stable and known at each rising edge while out of reset.
module phsub_checker #(
    parameter int VLEN = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [VLEN-1:0]   opa,
    input logic [VLEN-1:0]   opb,
    input logic [VLEN/8-1:0] pmask,
    input logic              out_valid,
    input logic [VLEN-1:0]   result
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0)); // R8

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(result)); // R7

    AST_EMPTY_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pmask == '0) |=> (result == $past(opa))); // R9

    AST_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opa == opb && (&pmask)) |=> (result == '0)); // R10

endmodule

bind phsub_core phsub_checker #(.VLEN(VLEN)) u_chk (.*);

// File: tb/phsub_core_test.sv
// phsub_core_test: seeded random plus directed checks against a bench model.
module phsub_core_test;

    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [1:0]      size_code;
    logic [VLEN-1:0] opa, opb;
    logic [PW-1:0]   pmask;
    logic            out_valid;
    logic [VLEN-1:0] result;

    int checks   = 0;
    int failures = 0;
    logic [VLEN-1:0] last_exp;

    always #5 clk = ~clk;

    phsub_core #(.VLEN(VLEN)) uut (
        .clk, .rst_n, .in_valid, .size_code, .opa, .opb, .pmask,
        .out_valid, .result
    );

    // Reference: per-lane (W+1)-bit difference, keep bits W..1.
    function automatic logic [VLEN-1:0] model(input logic [1:0] sz,
            input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
            input logic [PW-1:0] m);
        int w  = 8 << sz;
        int nl = VLEN / w;
        logic [64:0] lm = (w == 64) ? {1'b0, {64{1'b1}}} : ((65'd1 << w) - 65'd1);
        logic [VLEN-1:0] r = '0;
        for (int e = 0; e < nl; e++) begin
            logic [64:0] ea = 65'(a >> (e * w)) & lm;
            logic [64:0] eb = 65'(b >> (e * w)) & lm;
            logic [64:0] v;
            logic [VLEN-1:0] wide;
            if (m[e * w / 8]) v = ((ea - eb) >> 1) & lm;
            else              v = ea;
            wide = VLEN'(v);
            r = r | (wide << (e * w));
        end
        return r;
    endfunction

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic check(input string req, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation at a falling edge, check one clock later.
    task automatic do_op(input string req, input logic [1:0] sz,
            input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
            input logic [PW-1:0] m);
        @(negedge clk);
        size_code = sz; opa = a; opb = b; pmask = m; in_valid = 1'b1;
        @(negedge clk);
        check({req, " R6 valid"}, VLEN'(out_valid), VLEN'(1));
        last_exp = model(sz, a, b, m);
        check(req, result, last_exp);
        in_valid = 1'b0;
    endtask

    logic [VLEN-1:0] ones;
    logic [PW-1:0]   lowbits_clear;

    initial begin
        void'($urandom(32'd20240611));
        ones = '1;
        rst_n = 1'b0; in_valid = 1'b0; size_code = 2'd0;
        opa = '0; opb = '0; pmask = '0;
        repeat (3) @(negedge clk);
        check("R8 reset valid", VLEN'(out_valid), VLEN'(0));
        check("R8 reset result", result, '0);
        rst_n = 1'b1;

        // Directed corner cases per size code.
        for (int s = 0; s < 4; s++) begin
            logic [VLEN-1:0] r = rnd_vec();
            do_op("R10 equal operands", 2'(s), r, r, '1);
            do_op("R2 zero minus max", 2'(s), '0, ones, '1);
            do_op("R2 max minus zero", 2'(s), ones, '0, '1);
            do_op("R9 empty predicate", 2'(s), rnd_vec(), rnd_vec(), '0);
        end

        // Only non-governing predicate bits set for 64-bit lanes: all inactive.
        for (int k = 0; k < PW; k++) lowbits_clear[k] = (k % 8) != 0;
        do_op("R4 ignored mask bits", 2'd3, rnd_vec(), rnd_vec(), lowbits_clear);
        check("R4 passthrough equals opa", result, opa);

        // Borrow must not cross a lane: alternating lanes 0 - 1 and max - 0.
        do_op("R5 lane isolation", 2'd0, {(VLEN/16){8'hFF, 8'h00}},
              {(VLEN/16){8'h00, 8'h01}}, '1);

        // Random stimulus for every size code, with an idle hold check.
        for (int it = 0; it < 40; it++) begin
            for (int s = 0; s < 4; s++) begin
                do_op("R1 R3 random", 2'(s), rnd_vec(), rnd_vec(), PW'($urandom()));
            end
            @(negedge clk);
            opa = rnd_vec(); opb = rnd_vec(); pmask = PW'($urandom());
            check("R7 idle valid", VLEN'(out_valid), VLEN'(0));
            check("R7 hold", result, last_exp);
        end

        // Reset while an operation is offered.
        @(negedge clk);
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid reset valid", VLEN'(out_valid), VLEN'(0));
        check("R8 mid reset result", result, '0);
        in_valid = 1'b0; rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule